// File: doc/BRIEF.md
# 40-bit Accumulator Compare and Shift Unit

This block keeps a 40-bit signed accumulator, held as an 8-bit extension byte above a 16-bit high word and a 16-bit low word. It also keeps a status word with a saturation-mode control bit. Each valid cycle it carries out one operation: load the accumulator from two 16-bit operands, compare the accumulator against them, or shift the accumulator right logically or arithmetically by a count from 0 to 16. Software may also write the status word directly to preset or clear its flags.

All results are registered. The accumulator and status word show the effect of an operation in the cycle after it is presented. A compare reads the accumulator and never writes it. A right shift always works on the full 40 bits and is never clamped. The extension flag is judged from the shifted result in the same way with saturation mode on or off.

Top module: `acu_top`

## Requirements
- R1: After reset the accumulator reads 0 and the status word reads 16'h0000.
- R2: A load (opCode 3'd1) places {opHi, opLo}, sign-extended from bit 15 of opHi to 40 bits, in the accumulator; for example opLo=0, opHi=7 gives 40'h00_0007_0000. Load leaves the status word unchanged.
- R3: A compare (opCode 3'd2) forms accumulator minus the sign-extended {opHi, opLo} and leaves the accumulator unchanged. It sets C (bit 10) on an unsigned 40-bit borrow, Z (bit 9) when the difference is zero and N (bit 8) from bit 39 of the difference. It touches no other status bit.
- R4: A logical right shift (opCode 3'd3) fills vacated bits with zero. The count is shiftCnt, and any count above 16 acts as 16.
- R5: An arithmetic right shift (opCode 3'd4) fills vacated bits with bit 39. It uses the same count rule as R4.
- R6: A shift result is never saturated, whatever the saturation-mode bit (bit 0) holds.
- R7: After a shift, E (bit 12) is 1 exactly when accumulator bits 39..31 are not all equal. This holds the same way with saturation mode on or off.
- R8: A shift sets Z and N from the 40-bit result and clears C. SV (bit 11) and SL (bit 13) change only through a status write.
- R9: A status write (swWrEn) stores bits 0, 8..13 of swWrData and reads all other bits as 0. It wins over the flag update of an operation in the same cycle, while that operation still updates the accumulator.
- R10: With opValid low, or with opCode 3'd0 or 3'd5..3'd7, the accumulator and the operation flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 3 | 1 load, 2 compare, 3 logical shift, 4 arithmetic shift, others none |
| opLo | input | 16 | First operand, low word |
| opHi | input | 16 | Second operand, high word |
| shiftCnt | input | 5 | Right-shift distance, values above 16 act as 16 |
| swWrEn | input | 1 | Write the status word |
| swWrData | input | 16 | Status word write data |
| accExt | output | 8 | Accumulator bits 39..32 |
| accHigh | output | 16 | Accumulator bits 31..16 |
| accLow | output | 16 | Accumulator bits 15..0 |
| statusWord | output | 16 | Status word: sat 0, N 8, Z 9, C 10, SV 11, E 12, SL 13 |

## Verification
The bench checks compares whose order is wrong in each possible way. A design that subtracts in the reversed order reports C and N inverted on the 7-versus-6 and 7-versus-8 cases. The bench also compares a negative accumulator with a small positive operand, where signed and unsigned borrow disagree. For shifts, it checks the extension flag with saturation on and off on a value whose extension byte becomes significant; a design that follows the saturation bit there, or clamps the result, gives a wrong E or a wrong accumulator. Counts of 0, 16 and above 16 catch a count that is not clamped. A status write in the same cycle as a compare shows whether the write wins.

// File: rtl/acu_pkg.sv
package acu_pkg;
  localparam int SAT_BIT = 0;
  localparam int N_BIT   = 8;
  localparam int Z_BIT   = 9;
  localparam int C_BIT   = 10;
  localparam int SV_BIT  = 11;
  localparam int E_BIT   = 12;
  localparam int SL_BIT  = 13;
  localparam logic [15:0] SW_MASK = 16'h3F01;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_LOAD = 3'd1,
    OP_CMP  = 3'd2,
    OP_LSHR = 3'd3,
    OP_ASHR = 3'd4
  } acuOp_e;

  typedef struct packed {
    logic loadAcc;
    logic cmpFlags;
    logic shiftAcc;
    logic arithFill;
    logic swWrite;
  } acuStrobe_t;
endpackage

// File: rtl/acu_ctrl.sv
module acu_ctrl
  import acu_pkg::*;
(
  input  logic       opValid,
  input  logic [2:0] opCode,
  input  logic       swWrEn,
  output acuStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    strobe.swWrite = swWrEn;
    if (opValid) begin
      case (opCode)
        OP_LOAD: strobe.loadAcc  = 1'b1;
        OP_CMP:  strobe.cmpFlags = 1'b1;
        OP_LSHR: strobe.shiftAcc = 1'b1;
        OP_ASHR: begin
          strobe.shiftAcc  = 1'b1;
          strobe.arithFill = 1'b1;
        end
        default: strobe = '{default: 1'b0, swWrite: swWrEn};
      endcase
    end
  end
endmodule

// File: rtl/acu_datapath.sv
module acu_datapath
  import acu_pkg::*;
#(
  parameter int EXT_W     = 8,
  parameter int WORD_W    = 16,
  parameter int CNT_W     = 5,
  parameter int MAX_SHIFT = 16,
  localparam int ACC_W    = EXT_W + 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  acuStrobe_t        strobe,
  input  logic [WORD_W-1:0] opLo,
  input  logic [WORD_W-1:0] opHi,
  input  logic [CNT_W-1:0]  shiftCnt,
  input  logic [WORD_W-1:0] swWrData,
  output logic [ACC_W-1:0]  accOut,
  output logic [WORD_W-1:0] swOut
);
  localparam int SIGN_LO = 2 * WORD_W - 1;

  logic [ACC_W-1:0]  accReg, accNext, opSext, diff, shifted;
  logic [WORD_W-1:0] swReg, swNext;
  logic [CNT_W-1:0]  effCnt;
  logic              borrow, extSignif;

  assign opSext = {{EXT_W{opHi[WORD_W-1]}}, opHi, opLo};
  assign {borrow, diff} = {1'b0, accReg} - {1'b0, opSext};
  assign effCnt = (shiftCnt > CNT_W'(MAX_SHIFT)) ? CNT_W'(MAX_SHIFT) : shiftCnt;

  always_comb begin
    if (strobe.arithFill) shifted = ACC_W'($signed(accReg) >>> effCnt);
    else                  shifted = accReg >> effCnt;
  end

  assign extSignif = !((&shifted[ACC_W-1:SIGN_LO]) || !(|shifted[ACC_W-1:SIGN_LO]));

  always_comb begin
    accNext = accReg;
    if (strobe.loadAcc)       accNext = opSext;
    else if (strobe.shiftAcc) accNext = shifted;
  end

  always_comb begin
    swNext = swReg;
    if (strobe.swWrite) begin
      swNext = swWrData & WORD_W'(SW_MASK);
    end else if (strobe.cmpFlags) begin
      swNext[N_BIT] = diff[ACC_W-1];
      swNext[Z_BIT] = (diff == '0);
      swNext[C_BIT] = borrow;
    end else if (strobe.shiftAcc) begin
      swNext[N_BIT] = shifted[ACC_W-1];
      swNext[Z_BIT] = (shifted == '0);
      swNext[C_BIT] = 1'b0;
      swNext[E_BIT] = extSignif;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg <= '0;
      swReg  <= '0;
    end else begin
      accReg <= accNext;
      swReg  <= swNext;
    end
  end

  assign accOut = accReg;
  assign swOut  = swReg;
endmodule

// File: rtl/acu_top.sv
module acu_top
  import acu_pkg::*;
#(
  parameter int EXT_W     = 8,
  parameter int WORD_W    = 16,
  parameter int CNT_W     = 5,
  parameter int MAX_SHIFT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [WORD_W-1:0] opLo,
  input  logic [WORD_W-1:0] opHi,
  input  logic [CNT_W-1:0]  shiftCnt,
  input  logic              swWrEn,
  input  logic [WORD_W-1:0] swWrData,
  output logic [EXT_W-1:0]  accExt,
  output logic [WORD_W-1:0] accHigh,
  output logic [WORD_W-1:0] accLow,
  output logic [WORD_W-1:0] statusWord
);
  localparam int ACC_W = EXT_W + 2 * WORD_W;

  acuStrobe_t       strobe;
  logic [ACC_W-1:0] accAll;

  acu_ctrl u_ctrl (
    .opValid(opValid),
    .opCode (opCode),
    .swWrEn (swWrEn),
    .strobe (strobe)
  );

  acu_datapath #(
    .EXT_W(EXT_W), .WORD_W(WORD_W), .CNT_W(CNT_W), .MAX_SHIFT(MAX_SHIFT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opLo    (opLo),
    .opHi    (opHi),
    .shiftCnt(shiftCnt),
    .swWrData(swWrData),
    .accOut  (accAll),
    .swOut   (statusWord)
  );

  assign accExt  = accAll[ACC_W-1 -: EXT_W];
  assign accHigh = accAll[2*WORD_W-1 -: WORD_W];
  assign accLow  = accAll[WORD_W-1:0];
endmodule

// File: rtl/acu_checker.sv
module acu_checker
  import acu_pkg::*;
#(
  parameter int EXT_W  = 8,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [2:0]        opCode,
  input logic [WORD_W-1:0] opLo,
  input logic [WORD_W-1:0] opHi,
  input logic              swWrEn,
  input logic [EXT_W-1:0]  accExt,
  input logic [WORD_W-1:0] accHigh,
  input logic [WORD_W-1:0] accLow,
  input logic [WORD_W-1:0] statusWord
);
  localparam int ACC_W   = EXT_W + 2 * WORD_W;
  localparam int SIGN_LO = 2 * WORD_W - 1;

  logic [ACC_W-1:0] accFull, opSext;
  logic isLoad, isCmp, isShift, upperSame;

  assign accFull   = {accExt, accHigh, accLow};
  assign opSext    = {{EXT_W{opHi[WORD_W-1]}}, opHi, opLo};
  assign isLoad    = opValid && (opCode == 3'd1);
  assign isCmp     = opValid && (opCode == 3'd2);
  assign isShift   = opValid && (opCode == 3'd3 || opCode == 3'd4);
  assign upperSame = (&accFull[ACC_W-1:SIGN_LO]) || !(|accFull[ACC_W-1:SIGN_LO]);

  a_r2_load_value: assert property (@(posedge clk) disable iff (!rstN)
    isLoad |=> accFull == $past(opSext));

  a_r3_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rstN)
    isCmp |=> $stable(accFull));

  a_r3_cmp_borrow: assert property (@(posedge clk) disable iff (!rstN)
    (isCmp && !swWrEn) |=> statusWord[C_BIT] == ($past(accFull) < $past(opSext)));

  a_r7_ext_flag: assert property (@(posedge clk) disable iff (!rstN)
    (isShift && !swWrEn) |=> statusWord[E_BIT] == !upperSame);

  a_r8_shift_clears_c: assert property (@(posedge clk) disable iff (!rstN)
    (isShift && !swWrEn) |=> !statusWord[C_BIT]);

  a_r8_keep_sv_sl: assert property (@(posedge clk) disable iff (!rstN)
    !swWrEn |=> $stable(statusWord[SV_BIT]) && $stable(statusWord[SL_BIT]));

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid && !swWrEn) |=> $stable(accFull) && $stable(statusWord));
endmodule

bind acu_top acu_checker #(.EXT_W(EXT_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
  .opLo(opLo), .opHi(opHi), .swWrEn(swWrEn), .accExt(accExt),
  .accHigh(accHigh), .accLow(accLow), .statusWord(statusWord)
);

// File: tb/acu_top_tb.sv
module acu_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic [15:0] opLo = '0, opHi = '0, swWrData = '0;
  logic [4:0]  shiftCnt = '0;
  logic        swWrEn = 1'b0;
  logic [7:0]  accExt;
  logic [15:0] accHigh, accLow, statusWord;

  int checks = 0;
  int errors = 0;
  logic [39:0] expAcc = '0;
  logic [15:0] expSw = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  acu_top u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .opLo(opLo), .opHi(opHi), .shiftCnt(shiftCnt), .swWrEn(swWrEn),
    .swWrData(swWrData), .accExt(accExt), .accHigh(accHigh),
    .accLow(accLow), .statusWord(statusWord)
  );

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle, update the bench model from the requirements, compare.
  task automatic step(input logic valid, input logic [2:0] op, input logic [15:0] lo,
                      input logic [15:0] hi, input logic [4:0] cnt,
                      input logic wr, input logic [15:0] wd, input string tag);
    logic [39:0] sx, res, diff;
    int c;
    sx = {{8{hi[15]}}, hi, lo};
    c = (cnt > 16) ? 16 : int'(cnt);
    @(negedge clk);
    opValid = valid; opCode = op; opLo = lo; opHi = hi; shiftCnt = cnt;
    swWrEn = wr; swWrData = wd;
    if (valid && op == 3'd1) expAcc = sx;
    if (valid && op == 3'd2) begin
      diff = expAcc - sx;
      if (!wr) begin
        expSw[8] = diff[39]; expSw[9] = (diff == 0); expSw[10] = (expAcc < sx);
      end
    end
    if (valid && (op == 3'd3 || op == 3'd4)) begin
      res = expAcc;
      for (int i = 0; i < c; i++) res = {(op == 3'd4) ? res[39] : 1'b0, res[39:1]};
      expAcc = res;
      if (!wr) begin
        expSw[8] = res[39]; expSw[9] = (res == 0); expSw[10] = 1'b0;
        expSw[12] = !((res[39:31] == 9'h1FF) || (res[39:31] == 9'h000));
      end
    end
    if (wr) expSw = wd & 16'h3F01;
    @(negedge clk);
    opValid = 1'b0; swWrEn = 1'b0;
    check({tag, " acc"}, {accExt, accHigh, accLow}, expAcc);
    check({tag, " status"}, {24'h0, statusWord}, {24'h0, expSw});
  endtask

  task automatic t_r1_reset();
    check("R1 acc after reset", {accExt, accHigh, accLow}, 40'h0);
    check("R1 status after reset", {24'h0, statusWord}, 40'h0);
  endtask

  task automatic t_r2_load();
    step(1, 3'd1, 16'h0000, 16'h0007, 0, 0, 0, "R2 load 0,7");
    check("R2 literal 0x70000", {accExt, accHigh, accLow}, 40'h00_0007_0000);
    step(1, 3'd1, 16'h0000, 16'h8000, 0, 0, 0, "R2 load negative");
    check("R2 sign extension", {accExt, accHigh, accLow}, 40'hFF_8000_0000);
  endtask

  task automatic t_r3_compare();
    step(1, 3'd1, 16'h0000, 16'h0007, 0, 0, 0, "R3 setup");
    step(1, 3'd2, 16'h0000, 16'h0006, 0, 0, 0, "R3 acc>op");
    check("R3 acc>op flags", {24'h0, statusWord}, 40'h0000);
    step(1, 3'd2, 16'h0000, 16'h0008, 0, 0, 0, "R3 acc<op");
    check("R3 acc<op C and N", {24'h0, statusWord}, 40'h0500);
    step(1, 3'd2, 16'h0000, 16'h0007, 0, 0, 0, "R3 equal");
    check("R3 equal Z", {24'h0, statusWord}, 40'h0200);
    check("R3 acc untouched", {accExt, accHigh, accLow}, 40'h00_0007_0000);
    step(1, 3'd1, 16'h0000, 16'h8000, 0, 0, 0, "R3 setup neg");
    step(1, 3'd2, 16'h0001, 16'h0000, 0, 0, 0, "R3 unsigned borrow");
    check("R3 neg acc vs 1", {24'h0, statusWord}, 40'h0100);
  endtask

  task automatic t_r4_r5_shifts();
    step(1, 3'd1, 16'h5555, 16'hAAAA, 0, 0, 0, "R4 setup");
    step(1, 3'd3, 0, 0, 5'd4, 0, 0, "R4 lshr 4");
    check("R4 zero fill", {accExt, accHigh, accLow}, 40'h0F_FAAA_A555);
    step(1, 3'd3, 0, 0, 5'd0, 0, 0, "R4 lshr 0");
    step(1, 3'd1, 16'h5555, 16'hAAAA, 0, 0, 0, "R5 setup");
    step(1, 3'd4, 0, 0, 5'd20, 0, 0, "R5 ashr 20 acts as 16");
    check("R5 sign fill", {accExt, accHigh, accLow}, 40'hFF_FFFF_AAAA);
    step(1, 3'd3, 0, 0, 5'd16, 0, 0, "R4 lshr 16");
    check("R4 lshr 16 literal", {accExt, accHigh, accLow}, 40'h00_00FF_FFFF);
    step(1, 3'd1, 16'h0000, 16'h0000, 0, 0, 0, "R8 setup zero");
    step(1, 3'd3, 0, 0, 5'd3, 0, 0, "R8 Z after shift");
    check("R8 Z set", {24'h0, statusWord}, 40'h0200);
  endtask

  task automatic t_r6_r7_sat();
    step(1, 3'd1, 16'h0000, 16'h8000, 0, 0, 0, "R7 setup off");
    step(1, 3'd3, 0, 0, 5'd1, 0, 0, "R7 E sat off");
    check("R7 E set sat off", {24'h0, statusWord}, 40'h1000);
    step(0, 3'd0, 0, 0, 0, 1, 16'h2801, "R9 preset sat SV SL");
    step(1, 3'd1, 16'h0000, 16'h8000, 0, 0, 0, "R6 setup on");
    step(1, 3'd3, 0, 0, 5'd1, 0, 0, "R6 lshr sat on");
    check("R6 not saturated", {accExt, accHigh, accLow}, 40'h7F_C000_0000);
    check("R7 E set sat on", {24'h0, statusWord}, 40'h3801);
    step(1, 3'd1, 16'h0000, 16'h8000, 0, 0, 0, "R7 setup ashr");
    step(1, 3'd4, 0, 0, 5'd1, 0, 0, "R7 ashr E clear");
    check("R7 E clear, R8 SV SL kept", {24'h0, statusWord}, 40'h2901);
  endtask

  task automatic t_r8_r9_r10();
    step(0, 3'd0, 0, 0, 0, 1, 16'hFFFF, "R9 write all ones");
    check("R9 masked write", {24'h0, statusWord}, 40'h3F01);
    step(0, 3'd0, 0, 0, 0, 1, 16'h0400, "R8 preset C");
    step(1, 3'd3, 0, 0, 5'd2, 0, 0, "R8 shift clears C");
    check("R8 C cleared", {23'h0, statusWord[10]}, 40'h0);
    step(1, 3'd1, 16'h0000, 16'h0003, 0, 0, 0, "R9 setup");
    step(1, 3'd2, 16'h0000, 16'h0003, 0, 1, 16'h0000, "R9 write beats compare");
    check("R9 write wins", {24'h0, statusWord}, 40'h0);
    step(1, 3'd1, 16'h1111, 16'h2222, 0, 1, 16'h0800, "R9 write with load");
    step(0, 3'd1, 16'hDEAD, 16'hBEEF, 0, 0, 0, "R10 opValid low");
    check("R10 idle acc", {accExt, accHigh, accLow}, 40'h00_2222_1111);
    step(1, 3'd7, 16'hDEAD, 16'hBEEF, 5'd4, 0, 0, "R10 unused code");
    step(1, 3'd0, 16'hDEAD, 16'hBEEF, 5'd4, 0, 0, "R10 code zero");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_r1_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_r1_reset();
    t_r2_load();
    t_r3_compare();
    t_r4_r5_shifts();
    t_r6_r7_sat();
    t_r8_r9_r10();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule